// File: doc/BRIEF.md
# TFT panel gate and source timing generator

This block sits between the incoming video timing of one panel (data-enable, horizontal sync, vertical sync) and the row and column driver chips. From those three inputs it builds the control strobes the drivers need. The row side gets a start pulse once per frame, a shift clock once per line and output enables. The column side gets a latch strobe and an output-enable strobe at the end of every line. A pair of complementary line-inversion signals completes the set.

All timing is counted in output-clock periods. An output-clock period is the span between two system clock edges at which the half-rate enable `clk_en` is high; such an edge is called a tick below. Inputs are sampled only at ticks, and every sync input is active high.

After reset the block holds every driver control in its idle state, with the gate output enables low, so that the drivers can be cleared. It releases the outputs at the first rising edge of vertical sync. A line end counts only when a horizontal sync rising edge has been seen since the previous counted line end.

Top module: `tft_gate_src_timing`

## Requirements
- R1: During and after reset, until blanking is released, gate_start, gate_clk, col_latch and col_oe are 0, both gate_oe bits are 0, inv_p is 0 and inv_n is 1.
- R2: Blanking is released at the first tick at which vsync is sampled 1 after having been sampled 0 (a vsync rise). Line ends before that tick produce no strobe and no inversion change.
- R3: gate_start goes to 1 after every tick that samples a vsync rise. It returns to 0 at the next falling edge of gate_clk.
- R4: A counted line end is a tick at which de is sampled 0 after being sampled 1 at the previous tick. After tick k of a counted line end, col_latch is 1 for the 2 periods that start at ticks k and k+1.
- R5: col_oe is 1 for the 4 periods that start at ticks k+2 to k+5, directly after the latch strobe.
- R6: gate_clk is 1 for the 8 periods that start at ticks k+1 to k+8.
- R7: After release, both gate_oe bits are 1, except during the periods that start at ticks k to k+3 and k+8 to k+11, which bracket the rising and the falling edge of gate_clk.
- R8: inv_n is always the complement of inv_p. inv_p changes value at every counted line end.
- R9: When frame_inv_en is 1, inv_p also changes value at each vsync rise after release. When frame_inv_en is 0, a vsync rise leaves inv_p unchanged. The rise that releases blanking never changes inv_p.
- R10: A falling edge of de with no hsync rise since the previous counted line end is ignored: it causes no strobe and no inversion change.
- R11: At a clock edge where clk_en is 0, no output changes and no input is sampled.
- R12: A counted line end that occurs while a line-end sequence is still running restarts the sequence from its first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Output-clock enable; marks the ticks |
| de | input | 1 | Data-enable, high during active pixels |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| frame_inv_en | input | 1 | 1 = also invert polarity at each frame start |
| gate_start | output | 1 | Row driver start pulse |
| gate_clk | output | 1 | Row driver shift clock |
| col_latch | output | 1 | Column driver latch strobe |
| col_oe | output | 1 | Column driver output-enable strobe |
| gate_oe | output | 2 | Row driver output enables, one per bank |
| inv_p | output | 1 | Line-inversion control |
| inv_n | output | 1 | Complement of inv_p |

## Verification
The hardest situation to reach is a counted line end that lands in the middle of a running sequence, because normal video timing never produces one. The stimulus creates it with back-to-back lines whose active and porch intervals are much shorter than the 12-period sequence. A second hard case is a data-enable fall with no preceding horizontal sync. The stimulus produces this with a line that suppresses its sync pulse right after a valid line. Both cases are also run under an irregular enable pattern, so that the stretching of every window over stalled edges is exercised as well.

// File: rtl/tft_tg_pkg.sv
// Shared types and helpers for the TFT gate/source timing generator.
package tft_tg_pkg;

    // Per-tick events decoded from the video timing inputs.
    typedef struct packed {
        logic line_end;     // counted end of an active line
        logic frame_start;  // vertical sync rising edge
    } tg_evt_t;

    function automatic int tg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic tg_in(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/tft_tg_sync.sv
// Samples de/hsync/vsync on output-clock ticks and decodes line-end and
// frame-start events. Holds the blanking flag from reset to the first
// vertical sync rise. Assumes sync inputs are active high and already
// synchronous to clk.
module tft_tg_sync
    import tft_tg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clk_en,
    input  logic    de,
    input  logic    hsync,
    input  logic    vsync,
    output tg_evt_t evt,
    output logic    blank
);

    logic de_q, hs_q, vs_q, armed;
    logic de_fall, hs_rise, vs_rise;

    assign de_fall = de_q & ~de;
    assign hs_rise = ~hs_q & hsync;
    assign vs_rise = ~vs_q & vsync;

    assign evt.line_end    = clk_en & de_fall & armed & ~blank;
    assign evt.frame_start = clk_en & vs_rise;

    // Input history, line arming and blanking state, advanced on ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q  <= 1'b0;
            hs_q  <= 1'b0;
            vs_q  <= 1'b0;
            armed <= 1'b0;
            blank <= 1'b1;
        end else if (clk_en) begin
            de_q <= de;
            hs_q <= hsync;
            vs_q <= vsync;
            if (vs_rise)
                blank <= 1'b0;
            if (hs_rise)
                armed <= 1'b1;
            else if (evt.line_end)
                armed <= 1'b0;
        end
    end

    // Blanking persists until a frame start.
    p_blank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !evt.frame_start) |=> blank);

    // Once released, blanking never returns without reset.
    p_blank_gone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> !blank);

endmodule

// File: rtl/tft_tg_line.sv
// Line-end sequencer: one counter started by each counted line end drives
// the column latch, column output enable, gate clock and gate output-enable
// guard windows. Assumes GCK_DLY >= 1 and a line longer than the sequence
// for non-restarting operation.
module tft_tg_line
    import tft_tg_pkg::*;
#(
    parameter int LAT_LEN = 2,
    parameter int COE_LEN = 4,
    parameter int GCK_DLY = 2,
    parameter int GCK_LEN = 8,
    parameter int GUARD   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic line_end,
    input  logic blank,
    output logic col_latch,
    output logic col_oe,
    output logic gate_clk,
    output logic goe_ok,
    output logic gck_fall_nxt
);

    localparam int GCK_FALL = GCK_DLY + GCK_LEN;
    localparam int END_I    = tg_max(LAT_LEN + COE_LEN, GCK_FALL + GUARD - 2);
    localparam int CW       = $clog2(END_I + 1);
    localparam logic [CW-1:0] LC_END = CW'(END_I);

    logic [CW-1:0] lc, lc_nxt;
    int lc_i, lcn_i;

    assign lc_i  = int'(lc);
    assign lcn_i = int'(lc_nxt);

    // Next count: restart on a line end, else run to the end and park at 0.
    always_comb begin
        lc_nxt = lc;
        if (line_end)
            lc_nxt = CW'(1);
        else if (lc != '0)
            lc_nxt = (lc == LC_END) ? '0 : lc + 1'b1;
    end

    // Sequence counter, advanced on ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lc <= '0;
        else if (clk_en)
            lc <= lc_nxt;
    end

    // Strobe windows decoded from the counter.
    always_comb begin
        col_latch    = tg_in(lc_i, 1, LAT_LEN);
        col_oe       = tg_in(lc_i, LAT_LEN + 1, LAT_LEN + COE_LEN);
        gate_clk     = tg_in(lc_i, GCK_DLY, GCK_FALL - 1);
        goe_ok       = ~blank
                     & ~tg_in(lc_i, GCK_DLY - 1, GCK_DLY + GUARD - 2)
                     & ~tg_in(lc_i, GCK_FALL - 1, GCK_FALL + GUARD - 2);
        gck_fall_nxt = clk_en & gate_clk & ~tg_in(lcn_i, GCK_DLY, GCK_FALL - 1);
    end

    // Column output enable starts as the latch strobe ends.
    p_coe_after_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_latch) |-> $rose(col_oe));

    // Gate output enables are low across both gate clock edges.
    p_goe_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_clk) || $fell(gate_clk)) |-> !goe_ok);

    // A line end always restarts at the latch phase.
    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (col_latch && !col_oe && !gate_clk));

endmodule

// File: rtl/tft_tg_frame.sv
// Frame-level state: the gate start pulse and the line-inversion polarity.
// Polarity is forced to 0 while blanked and flips on counted line ends and,
// optionally, on frame starts. Assumes events are already qualified by the
// tick enable.
module tft_tg_frame
    import tft_tg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clk_en,
    input  tg_evt_t evt,
    input  logic    blank,
    input  logic    frame_inv_en,
    input  logic    gck_fall_nxt,
    output logic    gate_start,
    output logic    inv_pol
);

    // Gate start: set at frame start, cleared with the next gate clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_start <= 1'b0;
        else if (clk_en) begin
            if (evt.frame_start)
                gate_start <= 1'b1;
            else if (gck_fall_nxt)
                gate_start <= 1'b0;
        end
    end

    // Inversion polarity: reset while blanked, flip on line end or frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inv_pol <= 1'b0;
        else if (clk_en) begin
            if (blank)
                inv_pol <= 1'b0;
            else
                inv_pol <= inv_pol ^ evt.line_end ^ (evt.frame_start & frame_inv_en);
        end
    end

    // A frame start always raises the gate start pulse.
    p_start_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt.frame_start |=> gate_start);

    // A lone counted line end flips the polarity.
    p_inv_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && evt.line_end && !(evt.frame_start && frame_inv_en))
        |=> (inv_pol != $past(inv_pol)));

endmodule

// File: rtl/tft_gate_src_timing.sv
// Top of the TFT gate/source timing generator. Connects the input decoder,
// the line-end sequencer and the frame state, and fans the gate output
// enable out to OE_BANKS banks. Assumes clk_en marks output-clock ticks.
module tft_gate_src_timing
    import tft_tg_pkg::*;
#(
    parameter int LAT_LEN  = 2,
    parameter int COE_LEN  = 4,
    parameter int GCK_DLY  = 2,
    parameter int GCK_LEN  = 8,
    parameter int GUARD    = 4,
    parameter int OE_BANKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                de,
    input  logic                hsync,
    input  logic                vsync,
    input  logic                frame_inv_en,
    output logic                gate_start,
    output logic                gate_clk,
    output logic                col_latch,
    output logic                col_oe,
    output logic [OE_BANKS-1:0] gate_oe,
    output logic                inv_p,
    output logic                inv_n
);

    tg_evt_t evt;
    logic    blank, goe_ok, gck_fall_nxt, inv_pol;

    tft_tg_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .de     (de),
        .hsync  (hsync),
        .vsync  (vsync),
        .evt    (evt),
        .blank  (blank)
    );

    tft_tg_line #(
        .LAT_LEN (LAT_LEN),
        .COE_LEN (COE_LEN),
        .GCK_DLY (GCK_DLY),
        .GCK_LEN (GCK_LEN),
        .GUARD   (GUARD)
    ) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .line_end     (evt.line_end),
        .blank        (blank),
        .col_latch    (col_latch),
        .col_oe       (col_oe),
        .gate_clk     (gate_clk),
        .goe_ok       (goe_ok),
        .gck_fall_nxt (gck_fall_nxt)
    );

    tft_tg_frame u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .evt          (evt),
        .blank        (blank),
        .frame_inv_en (frame_inv_en),
        .gck_fall_nxt (gck_fall_nxt),
        .gate_start   (gate_start),
        .inv_pol      (inv_pol)
    );

    // One gate output enable per bank.
    for (genvar b = 0; b < OE_BANKS; b++) begin : g_oe
        assign gate_oe[b] = goe_ok;
    end

    assign inv_p = inv_pol;
    assign inv_n = ~inv_pol;

    // Gate start ends only together with a gate clock fall.
    p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_start) |-> $fell(gate_clk));

    // Nothing moves across a stalled edge.
    p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable({gate_start, gate_clk, col_latch, col_oe, gate_oe, inv_p, inv_n}));

endmodule

// File: tb/tft_gate_src_timing_tb.sv
// Bench for tft_gate_src_timing: a behavioural reference model advanced on
// every tick, compared with the outputs at every falling clock edge.
module tft_gate_src_timing_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic de = 1'b0, hs = 1'b0, vs = 1'b0, fen = 1'b0;
    logic gate_start, gate_clk, col_latch, col_oe, inv_p, inv_n;
    logic [1:0] gate_oe;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit run_cmp = 1'b0;
    int en_mode = 0;
    logic [7:0] lfsr = 8'h5A;
    int latch_seen = 0;

    always #10 clk = ~clk;

    tft_gate_src_timing dut_i (
        .clk (clk), .rst_n (rst_n), .clk_en (en), .de (de), .hsync (hs),
        .vsync (vs), .frame_inv_en (fen), .gate_start (gate_start),
        .gate_clk (gate_clk), .col_latch (col_latch), .col_oe (col_oe),
        .gate_oe (gate_oe), .inv_p (inv_p), .inv_n (inv_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Enable pattern: half rate or irregular.
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (en_mode == 0) en <= ~en;
        else en <= lfsr[0] | lfsr[2];
    end

    // Reference model state; since = ticks since counted line end, -1 idle.
    bit m_de, m_hs, m_vs, m_blank = 1'b1, m_armed, m_gs, m_pol;
    int since = -1;

    function automatic bit gck_of(input int s);
        return (s >= 1) && (s <= 8);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_de = 0; m_hs = 0; m_vs = 0; m_blank = 1; m_armed = 0;
            m_gs = 0; m_pol = 0; since = -1;
        end else if (en) begin
            bit fall, hsr, vsr, le, old_g;
            int ns;
            fall = m_de && !de;
            hsr  = !m_hs && hs;
            vsr  = !m_vs && vs;
            le   = fall && m_armed && !m_blank;
            old_g = gck_of(since);
            if (le) ns = 0;
            else if (since >= 0) ns = (since + 1 > 11) ? -1 : since + 1;
            else ns = -1;
            if (vsr) m_gs = 1;
            else if (old_g && !gck_of(ns)) m_gs = 0;
            if (m_blank) m_pol = 0;
            else m_pol = m_pol ^ le ^ (vsr && fen);
            if (vsr) m_blank = 0;
            if (hsr) m_armed = 1;
            else if (le) m_armed = 0;
            since = ns;
            m_de = de; m_hs = hs; m_vs = vs;
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (run_cmp && rst_n && !done) begin
            bit lat, coe, goe;
            lat = (since >= 0) && (since <= 1);
            coe = (since >= 2) && (since <= 5);
            goe = !m_blank && !((since >= 0 && since <= 3) || (since >= 8 && since <= 11));
            if (col_latch) latch_seen++;
            chk(m_blank ? "R1 col_latch" : "R4 col_latch", col_latch, lat);
            chk(m_blank ? "R1 col_oe" : "R5 col_oe", col_oe, coe);
            chk(m_blank ? "R1 gate_clk" : "R6 gate_clk", gate_clk, gck_of(since));
            chk(m_blank ? "R1 gate_oe" : "R7 gate_oe", gate_oe, goe ? 3 : 0);
            chk("R3 gate_start", gate_start, m_gs);
            chk("R8 inv_p", inv_p, m_pol);
            chk("R8 inv_n", inv_n, !m_pol);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; ) begin
            @(posedge clk);
            if (en) i++;
        end
        @(negedge clk);
    endtask

    task automatic line(input int act, input int porch, input bit with_hs);
        if (with_hs) begin hs = 1; ticks(1); hs = 0; ticks(1); end
        de = 1; ticks(act);
        de = 0; ticks(porch);
    endtask

    // Frame start with polarity check after the rising tick (R9).
    task automatic frame(input bit exp_flip, input string tag);
        int p0;
        p0 = inv_p;
        vs = 1; ticks(1);
        chk(tag, inv_p, exp_flip ? (p0 ^ 1) : p0);
        chk("R3 gate_start after vsync", gate_start, 1);
        ticks(1); vs = 0; ticks(3);
    endtask

    initial begin
        int p;
        repeat (4) @(negedge clk);
        run_cmp = 1;
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset gate_oe", gate_oe, 0);
        chk("R1 reset inv_n", inv_n, 1);
        chk("R1 reset gate_start", gate_start, 0);
        // R2: a line before any vsync is ignored
        latch_seen = 0;
        line(6, 16, 1);
        chk("R2 no latch before vsync", latch_seen, 0);
        chk("R2 inv_p before vsync", inv_p, 0);
        // release; releasing rise never flips (R9)
        fen = 1;
        frame(0, "R9 release rise keeps inv_p");
        fen = 0;
        for (int i = 0; i < 3; i++) line(8, 16, 1);
        frame(0, "R9 frame mode off keeps inv_p");
        line(8, 16, 1);
        // R10: de fall without hsync
        p = inv_p; latch_seen = 0;
        line(8, 16, 0);
        chk("R10 ignored line no latch", latch_seen, 0);
        chk("R10 ignored line inv_p", inv_p, p);
        line(8, 16, 1);
        // R9: frame mode on
        fen = 1;
        frame(1, "R9 frame mode flips inv_p");
        for (int i = 0; i < 2; i++) line(8, 16, 1);
        // R12: back-to-back short lines restart the sequence
        for (int i = 0; i < 4; i++) line(2, 1, 1);
        ticks(16);
        // R11: irregular enable
        en_mode = 1;
        frame(1, "R11 R9 flip under irregular enable");
        for (int i = 0; i < 3; i++) line(6, 14, 1);
        for (int i = 0; i < 3; i++) line(3, 2, 1);
        ticks(16);
        fen = 0;
        frame(0, "R11 R9 no flip under irregular enable");
        line(5, 16, 1);
        ticks(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule